// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the software-visible register file of a multi-channel DMA controller. A simple word-addressed bus port reaches two areas. The first is a small global area with a control word, two interrupt mask words and two interrupt source words. The second is a run of identical per-channel windows. Each window holds the following registers:

- a channel control/status word
- a size word
- source and destination addresses, each with an address-wrap mask
- a descriptor pointer
- a software pointer

Every channel's registers are driven out continuously, so the transfer engines can use them as configuration. The engines push status back through per-channel set and clear vectors, and they raise interrupt-source bits through one strobe per channel. The block combines the sources with their masks into a single registered interrupt request. Some status bits clear themselves when software reads the control word. Writes from software reach only the configuration bits of that word. Accesses to offsets that are misaligned or do not exist answer with zero data and a one-cycle error pulse.

Top module: `dma_regbank`

## Requirements
- R1: After reset, the source mask and destination mask of every channel read 0xFFFFFFFC. Every other register reads zero, and irq_o, bus_err_o and bus_rdata_o are low.
- R2: Channel c occupies byte offsets 0x20 + 0x20*c up to 0x3F + 0x20*c. Inside the window the words are: control +0x00, size +0x04, source address +0x08, source mask +0x0C, destination address +0x10, destination mask +0x14, descriptor pointer +0x18, software pointer +0x1C. All words except the control word store and return full 32-bit writes.
- R3: The global words are control 0x00, mask A 0x04, mask B 0x08, source A 0x0C and source B 0x10. Mask A and source A keep one bit per channel (bit c = channel c) and read zero above it. The other global words keep 32 bits.
- R4: A read of a channel control word returns the value from before the read. Afterwards, bits 12 (error), 16 (chunk interrupt), 17 (done interrupt) and 18 (error interrupt) are clear. All other bits, including bit 11 (done), are unchanged.
- R5: A software write to a channel control word changes only the bits in mask 0x0000E3FF and keeps every other bit.
- R6: For each channel, the bits in eng_csr_set_i are set in the control word at the next edge. The bits in eng_csr_clr_i are cleared at the next edge. A set wins over a clear and over a read-clear of the same bit in the same cycle.
- R7: An access is illegal in three cases: the offset is not a multiple of 4, it is a global offset from 0x14 to 0x1C, or it selects a channel number of NCH or higher. An illegal read returns zero. An illegal write changes nothing. bus_err_o is high in the cycle after each illegal access and low after each legal one.
- R8: A high bit c of eng_irq_set_i sets bit c of source A at the next edge, even when software writes source A in the same cycle.
- R9: irq_o is high exactly when some channel has both its source A bit and its mask A bit set, delayed by one clock after the registers change.
- R10: bus_rdata_o carries the read word in the cycle after a legal read and is zero in the cycle after any other cycle.
- R11: The cfg_* outputs of channel c show that channel's current control, size, address, mask and pointer words at bit positions [32*c+31 : 32*c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_en_i | input | 1 | Access strobe for one cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_err_o | output | 1 | Illegal-access pulse, registered |
| eng_csr_set_i | input | NCH*32 | Per-channel control bits to set |
| eng_csr_clr_i | input | NCH*32 | Per-channel control bits to clear |
| eng_irq_set_i | input | NCH | Per-channel source A set strobe |
| cfg_csr_o | output | NCH*32 | Channel control words |
| cfg_size_o | output | NCH*32 | Channel size words |
| cfg_src_o | output | NCH*32 | Source addresses |
| cfg_srcmsk_o | output | NCH*32 | Source address masks |
| cfg_dst_o | output | NCH*32 | Destination addresses |
| cfg_dstmsk_o | output | NCH*32 | Destination address masks |
| cfg_desc_o | output | NCH*32 | Descriptor pointers |
| cfg_swptr_o | output | NCH*32 | Software pointers |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
The assertions check the following on every cycle:

- A control-word read leaves the read-clear bits low unless an engine set them in the same cycle.
- A software write leaves the protected control bits alone.
- Engine sets always stick.
- irq_o follows the masked sources one cycle later.
- Illegal reads return zero and raise the error pulse.

Only the bench scenarios can show the address map itself, the reset values, the ordering of a read against an engine set, and the protection against an illegal write. The bench shows that last point by reading back the register that a misaligned write would have hit.

// File: rtl/dmarb_pkg.sv
package dmarb_pkg;
  localparam int DW       = 32;
  localparam int CH_BASE  = 32;   // byte offset of channel 0 window
  localparam int WIN_LG   = 5;    // log2 of window size in bytes
  localparam int NREG     = 8;    // words per channel window
  localparam int SELW     = 3;

  localparam logic [DW-1:0] CSR_WMASK  = 32'h0000_E3FF;
  localparam logic [DW-1:0] CSR_RCMASK = 32'h0007_1000;
  localparam logic [DW-1:0] AMASK_RST  = 32'hFFFF_FFFC;

  typedef enum logic [SELW-1:0] {
    C_CSR, C_SIZE, C_SRC, C_SRCMSK, C_DST, C_DSTMSK, C_DESC, C_SWPTR
  } creg_e;

  typedef enum logic [SELW-1:0] {
    G_CTRL, G_MSKA, G_MSKB, G_SRCA, G_SRCB
  } greg_e;
endpackage

// File: rtl/dmarb_decode.sv
module dmarb_decode
  import dmarb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12
) (
  input  logic [AW-1:0]   addr_i,
  output logic            glb_o,
  output logic [NCH-1:0]  ch_hit_o,
  output logic [SELW-1:0] sel_o,
  output logic            legal_o
);
  localparam int WW = AW - 2;
  localparam int CW = AW - WIN_LG;
  localparam logic [WW-1:0] BASEW = WW'(CH_BASE / 4);

  logic [WW-1:0] rel;

  always_comb begin
    rel      = addr_i[AW-1:2] - BASEW;
    glb_o    = 1'b0;
    ch_hit_o = '0;
    sel_o    = '0;
    legal_o  = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i[AW-1:2] < BASEW) begin
        sel_o = addr_i[4:2];
        if (addr_i[4:2] <= G_SRCB) begin
          glb_o   = 1'b1;
          legal_o = 1'b1;
        end
      end else begin
        sel_o = rel[SELW-1:0];
        for (int i = 0; i < NCH; i++) begin
          if (rel[WW-1:SELW] == CW'(i)) begin
            ch_hit_o[i] = 1'b1;
            legal_o     = 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/dmarb_chan.sv
module dmarb_chan
  import dmarb_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [SELW-1:0]         sel_i,
  input  logic [DW-1:0]           wdata_i,
  input  logic [DW-1:0]           eng_set_i,
  input  logic [DW-1:0]           eng_clr_i,
  output logic [NREG-1:0][DW-1:0] regs_o
);
  logic [NREG-1:0][DW-1:0] regs_q, regs_n;

  always_comb begin
    regs_n = regs_q;
    for (int k = 1; k < NREG; k++) begin
      if (wr_i && sel_i == SELW'(k)) regs_n[k] = wdata_i;
    end
    if (wr_i && sel_i == C_CSR)
      regs_n[C_CSR] = (regs_q[C_CSR] & ~CSR_WMASK) | (wdata_i & CSR_WMASK);
    if (rd_i && sel_i == C_CSR)
      regs_n[C_CSR] = regs_n[C_CSR] & ~CSR_RCMASK;
    regs_n[C_CSR] = (regs_n[C_CSR] & ~eng_clr_i) | eng_set_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      regs_q           <= '0;
      regs_q[C_SRCMSK] <= AMASK_RST;
      regs_q[C_DSTMSK] <= AMASK_RST;
    end else begin
      regs_q <= regs_n;
    end
  end

  assign regs_o = regs_q;

  // R4: read-clear bits are low after a control read unless an engine set them
  a_r4_read_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && sel_i == C_CSR) |=> ((regs_q[C_CSR] & CSR_RCMASK & ~$past(eng_set_i)) == '0));

  // R5: protected control bits survive a software write
  a_r5_write_mask: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && sel_i == C_CSR && eng_set_i == '0 && eng_clr_i == '0)
      |=> ((regs_q[C_CSR] & ~CSR_WMASK) == ($past(regs_q[C_CSR]) & ~CSR_WMASK)));

  // R6: engine set bits always land
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (rst_i)
    (eng_set_i != '0) |=> ((regs_q[C_CSR] & $past(eng_set_i)) == $past(eng_set_i)));
endmodule

// File: rtl/dmarb_global.sv
module dmarb_global
  import dmarb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            wr_i,
  input  logic [SELW-1:0] sel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NCH-1:0]  irq_set_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o
);
  logic [DW-1:0]  ctrl_q, mskb_q, srcb_q;
  logic [NCH-1:0] mska_q, srca_q, srca_n;
  logic           irq_q;

  always_comb begin
    srca_n = srca_q;
    if (wr_i && sel_i == G_SRCA) srca_n = wdata_i[NCH-1:0];
    srca_n = srca_n | irq_set_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
      mskb_q <= '0;
      srcb_q <= '0;
      mska_q <= '0;
      srca_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_i && sel_i == G_CTRL) ctrl_q <= wdata_i;
      if (wr_i && sel_i == G_MSKA) mska_q <= wdata_i[NCH-1:0];
      if (wr_i && sel_i == G_MSKB) mskb_q <= wdata_i;
      if (wr_i && sel_i == G_SRCB) srcb_q <= wdata_i;
      srca_q <= srca_n;
      irq_q  <= |(srca_q & mska_q);
    end
  end

  always_comb begin
    case (sel_i)
      G_CTRL:  rdata_o = ctrl_q;
      G_MSKA:  rdata_o = DW'(mska_q);
      G_MSKB:  rdata_o = mskb_q;
      G_SRCA:  rdata_o = DW'(srca_q);
      G_SRCB:  rdata_o = srcb_q;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = irq_q;

  // R8: engine interrupt strobes always reach source A
  a_r8_irq_set_sticks: assert property (@(posedge clk_i) disable iff (rst_i)
    (irq_set_i != '0) |=> ((srca_q & $past(irq_set_i)) == $past(irq_set_i)));

  // R9: request follows masked sources by one clock
  a_r9_irq_follows: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (irq_o == |($past(srca_q) & $past(mska_q))));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dmarb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 12
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              bus_en_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DW-1:0]     bus_wdata_i,
  output logic [DW-1:0]     bus_rdata_o,
  output logic              bus_err_o,
  input  logic [NCH*DW-1:0] eng_csr_set_i,
  input  logic [NCH*DW-1:0] eng_csr_clr_i,
  input  logic [NCH-1:0]    eng_irq_set_i,
  output logic [NCH*DW-1:0] cfg_csr_o,
  output logic [NCH*DW-1:0] cfg_size_o,
  output logic [NCH*DW-1:0] cfg_src_o,
  output logic [NCH*DW-1:0] cfg_srcmsk_o,
  output logic [NCH*DW-1:0] cfg_dst_o,
  output logic [NCH*DW-1:0] cfg_dstmsk_o,
  output logic [NCH*DW-1:0] cfg_desc_o,
  output logic [NCH*DW-1:0] cfg_swptr_o,
  output logic              irq_o
);
  logic                             glb_hit, legal, rd, wr;
  logic [NCH-1:0]                   ch_hit;
  logic [SELW-1:0]                  sel;
  logic [DW-1:0]                    glb_rdata, ch_rdata, rdata_q;
  logic                             err_q;
  logic [NCH-1:0][NREG-1:0][DW-1:0] ch_regs;

  assign rd = bus_en_i & ~bus_we_i;
  assign wr = bus_en_i & bus_we_i;

  dmarb_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr_i   (bus_addr_i),
    .glb_o    (glb_hit),
    .ch_hit_o (ch_hit),
    .sel_o    (sel),
    .legal_o  (legal)
  );

  dmarb_global #(.NCH(NCH)) u_glb (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_i      (wr & glb_hit),
    .sel_i     (sel),
    .wdata_i   (bus_wdata_i),
    .irq_set_i (eng_irq_set_i),
    .rdata_o   (glb_rdata),
    .irq_o     (irq_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dmarb_chan u_ch (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .wr_i      (wr & ch_hit[i]),
      .rd_i      (rd & ch_hit[i]),
      .sel_i     (sel),
      .wdata_i   (bus_wdata_i),
      .eng_set_i (eng_csr_set_i[i*DW +: DW]),
      .eng_clr_i (eng_csr_clr_i[i*DW +: DW]),
      .regs_o    (ch_regs[i])
    );
    assign cfg_csr_o   [i*DW +: DW] = ch_regs[i][C_CSR];
    assign cfg_size_o  [i*DW +: DW] = ch_regs[i][C_SIZE];
    assign cfg_src_o   [i*DW +: DW] = ch_regs[i][C_SRC];
    assign cfg_srcmsk_o[i*DW +: DW] = ch_regs[i][C_SRCMSK];
    assign cfg_dst_o   [i*DW +: DW] = ch_regs[i][C_DST];
    assign cfg_dstmsk_o[i*DW +: DW] = ch_regs[i][C_DSTMSK];
    assign cfg_desc_o  [i*DW +: DW] = ch_regs[i][C_DESC];
    assign cfg_swptr_o [i*DW +: DW] = ch_regs[i][C_SWPTR];
  end

  always_comb begin
    ch_rdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) ch_rdata = ch_rdata | ch_regs[i][sel];
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      rdata_q <= (rd && legal) ? (glb_hit ? glb_rdata : ch_rdata) : '0;
      err_q   <= bus_en_i & ~legal;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign bus_err_o   = err_q;

  // R7: an illegal read answers zero and flags an error
  a_r7_illegal_read: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd && !legal) |=> (bus_rdata_o == '0 && bus_err_o));

  // R7: legal accesses never flag an error
  a_r7_legal_no_err: assert property (@(posedge clk_i) disable iff (rst_i)
    (bus_en_i && legal) |=> !bus_err_o);

  // R10: no read, no data
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (rst_i)
    (!rd) |=> (bus_rdata_o == '0));
endmodule

// File: tb/test_dma_regbank.sv
`timescale 1ns/1ps
module test_dma_regbank;
  localparam int NCH = 4;
  localparam int AW  = 12;
  localparam logic [31:0] WM = 32'h0000_E3FF;
  localparam logic [31:0] RC = 32'h0007_1000;

  logic clk = 1'b0, rst = 1'b1;
  logic en = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, irq;
  logic [NCH*32-1:0] eset = '0, eclr = '0;
  logic [NCH-1:0] eirq = '0;
  logic [NCH*32-1:0] c_csr, c_size, c_src, c_srcm, c_dst, c_dstm, c_desc, c_swp;

  int checks = 0, errors = 0;
  logic [31:0] m_ch [NCH][8];
  logic [31:0] m_ctrl, m_mskb, m_srcb;
  logic [NCH-1:0] m_mska, m_srca;
  logic [31:0] rv;
  logic le;

  always #2 clk = ~clk;

  dma_regbank #(.NCH(NCH), .AW(AW)) i_dma_regbank (
    .clk_i(clk), .rst_i(rst), .bus_en_i(en), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .bus_err_o(err),
    .eng_csr_set_i(eset), .eng_csr_clr_i(eclr), .eng_irq_set_i(eirq),
    .cfg_csr_o(c_csr), .cfg_size_o(c_size), .cfg_src_o(c_src), .cfg_srcmsk_o(c_srcm),
    .cfg_dst_o(c_dst), .cfg_dstmsk_o(c_dstm), .cfg_desc_o(c_desc), .cfg_swptr_o(c_swp),
    .irq_o(irq)
  );

  function automatic logic [AW-1:0] ch_addr(int c, int r);
    return AW'(32 + c * 32 + r * 4);
  endfunction
  function automatic logic [31:0] csr_after_write(logic [31:0] old, logic [31:0] w);
    return (old & ~WM) | (w & WM);
  endfunction
  function automatic logic [31:0] reset_val(int r);
    return (r == 3 || r == 5) ? 32'hFFFF_FFFC : 32'h0;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) m_ch[c][r] = reset_val(r);
    m_ctrl = '0; m_mskb = '0; m_srcb = '0; m_mska = '0; m_srca = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  // one access; returns the registered data and error seen the cycle after
  task automatic access(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                        output logic [31:0] rd_o, output logic err_o);
    @(negedge clk);
    en = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    en = 1'b0; we = 1'b0; eset = '0; eclr = '0; eirq = '0;
    rd_o = rdata; err_o = err;
  endtask

  task automatic irq_chk(string tag);
    @(negedge clk);
    chk(tag, 32'(irq), 32'(|(m_srca & m_mska)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    // R1: reset values
    chk("R1 irq", 32'(irq), 0);
    chk("R1 err", 32'(err), 0);
    chk("R1 rdata", rdata, 0);
    for (int c = 0; c < NCH; c++)
      for (int r = 0; r < 8; r++) begin
        access(1'b0, ch_addr(c, r), 0, rv, le);
        chk($sformatf("R1 ch%0d reg%0d", c, r), rv, reset_val(r));
      end
    for (int g = 0; g < 5; g++) begin
      access(1'b0, AW'(g * 4), 0, rv, le);
      chk("R1 global", rv, 0);
    end
    chk("R11 srcmask cfg reset", c_srcm[32*2 +: 32], 32'hFFFF_FFFC);

    // R5: masked control write
    access(1'b1, ch_addr(1, 0), 32'hFFFF_FFFF, rv, le);
    chk("R10 zero after write", rv, 0);
    access(1'b0, ch_addr(1, 0), 0, rv, le);
    chk("R5 masked write", rv, WM);
    chk("R11 csr cfg", c_csr[32*1 +: 32], WM);

    // R4: read-clear bits 12,16,17,18 go, done bit 11 stays
    @(negedge clk); eset[32*1 +: 32] = 32'h0007_1800;
    @(negedge clk); eset = '0;
    access(1'b0, ch_addr(1, 0), 0, rv, le);
    chk("R4 read returns pre-clear", rv, WM | 32'h0007_1800);
    access(1'b0, ch_addr(1, 0), 0, rv, le);
    chk("R4 after clear", rv, WM | 32'h0000_0800);

    // R6: engine set beats read-clear in the same cycle
    @(negedge clk);
    eset[32*1 +: 32] = 32'h0002_0000;
    en = 1'b1; we = 1'b0; addr = ch_addr(1, 0);
    @(negedge clk); en = 1'b0; eset = '0;
    chk("R6 read sees old value", rdata, WM | 32'h0000_0800);
    access(1'b0, ch_addr(1, 0), 0, rv, le);
    chk("R6 set won over read-clear", rv, WM | 32'h0002_0800);
    // R6: clear vs set, set wins
    @(negedge clk);
    eclr[32*1 +: 32] = 32'h0000_0401; eset[32*1 +: 32] = 32'h0000_0400;
    @(negedge clk); eclr = '0; eset = '0;
    chk("R6 clr and set cfg", c_csr[32*1 +: 32], (WM & ~32'h1) | 32'h0000_0C00);

    // R7: illegal accesses
    access(1'b1, AW'(12'h022), 32'hFFFF_FFFF, rv, le);
    chk("R7 misaligned write err", 32'(le), 1);
    access(1'b0, ch_addr(0, 0), 0, rv, le);
    chk("R7 misaligned write ignored", rv, 0);
    chk("R7 legal read no err", 32'(le), 0);
    access(1'b0, AW'(12'h014), 0, rv, le);
    chk("R7 hole read data", rv, 0);
    chk("R7 hole read err", 32'(le), 1);
    access(1'b1, ch_addr(NCH, 1), 32'h1234_5678, rv, le);
    chk("R7 channel out of range err", 32'(le), 1);
    access(1'b0, ch_addr(NCH, 1), 0, rv, le);
    chk("R7 channel out of range data", rv, 0);

    // R8/R9: interrupt path
    do_reset();
    access(1'b1, AW'(12'h004), 32'h0000_0004, rv, le); m_mska = 4'h4;
    irq_chk("R9 mask only");
    @(negedge clk); eirq = 4'h4;
    @(negedge clk); eirq = '0; m_srca = 4'h4;
    @(negedge clk);
    chk("R9 irq raised", 32'(irq), 1);
    @(negedge clk); eirq = 4'h4;
    en = 1'b1; we = 1'b1; addr = AW'(12'h00C); wdata = 32'h0;
    @(negedge clk); en = 1'b0; we = 1'b0; eirq = '0;
    access(1'b0, AW'(12'h00C), 0, rv, le);
    chk("R8 engine set beats write", rv, 32'h4);
    access(1'b1, AW'(12'h00C), 32'hFFFF_FFF0, rv, le); m_srca = '0;
    irq_chk("R9 irq cleared");
    access(1'b0, AW'(12'h00C), 0, rv, le);
    chk("R3 source A width", rv, 0);
    access(1'b1, AW'(12'h00C), 32'hFFFF_FFFF, rv, le); m_srca = 4'hF;
    access(1'b0, AW'(12'h00C), 0, rv, le);
    chk("R3 source A upper bits zero", rv, 32'hF);

    // random phase against the model (R2, R3, R4, R5, R7, R9, R10, R11)
    do_reset();
    for (int n = 0; n < 600; n++) begin
      int c, r, g, kind;
      logic [31:0] d;
      c = $urandom_range(0, NCH - 1);
      r = $urandom_range(0, 7);
      g = $urandom_range(0, 4);
      d = $urandom;
      kind = $urandom_range(0, 9);
      if (kind <= 3) begin
        access(1'b1, ch_addr(c, r), d, rv, le);
        m_ch[c][r] = (r == 0) ? csr_after_write(m_ch[c][r], d) : d;
        chk("R10 write gives zero data", rv, 0);
      end else if (kind <= 5) begin
        access(1'b0, ch_addr(c, r), 0, rv, le);
        chk($sformatf("R2 ch%0d reg%0d", c, r), rv, m_ch[c][r]);
        if (r == 0) m_ch[c][0] = m_ch[c][0] & ~RC;
      end else if (kind == 6) begin
        access(1'b1, AW'(g * 4), d, rv, le);
        case (g)
          0: m_ctrl = d;
          1: m_mska = d[NCH-1:0];
          2: m_mskb = d;
          3: m_srca = d[NCH-1:0];
          default: m_srcb = d;
        endcase
        irq_chk("R9 random irq");
      end else if (kind == 7) begin
        logic [31:0] e;
        access(1'b0, AW'(g * 4), 0, rv, le);
        case (g)
          0: e = m_ctrl;
          1: e = 32'(m_mska);
          2: e = m_mskb;
          3: e = 32'(m_srca);
          default: e = m_srcb;
        endcase
        chk("R3 global read", rv, e);
      end else if (kind == 8) begin
        access(1'b1, ch_addr(c, r) + AW'($urandom_range(1, 3)), d, rv, le);
        chk("R7 random misaligned err", 32'(le), 1);
      end else begin
        chk("R11 cfg size", c_size[32*c +: 32], m_ch[c][1]);
        chk("R11 cfg dst", c_dst[32*c +: 32], m_ch[c][4]);
        chk("R11 cfg swptr", c_swp[32*c +: 32], m_ch[c][7]);
        chk("R11 cfg desc", c_desc[32*c +: 32], m_ch[c][6]);
        chk("R11 cfg dstmask", c_dstm[32*c +: 32], m_ch[c][5]);
        chk("R11 cfg src", c_src[32*c +: 32], m_ch[c][2]);
        @(negedge clk);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule